// File: doc/BRIEF.md
# Global 64-bit Comparator Timer

This block keeps a free-running 64-bit up-counter and one 64-bit comparator that raises a level interrupt when the two are equal. Software reaches every register through a 32-bit word-addressed register bus (address, write data, write enable, combinational read data). Both the counter and the comparator are split into a low word and a high word. To read the counter consistently, software reads the high word, then the low word, then the high word again, and retries if the two high reads differ.

The comparator runs in one of two ways. In one-shot use it fires once and keeps its value. In periodic use it adds a programmed 32-bit step to itself on every match, so the interrupt comes back at a fixed interval. Every write to a timed register is confirmed by a sticky write-status bit, and software clears that bit by writing one to it. A driver can therefore confirm that each value it wrote has taken effect.

Top module: `gct_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The counter is written per half: word 0 is the low half and word 1 is the high half, and the counter reads back on the same words. It holds while the run bit is clear. It adds one per clock while the run bit is set, and it carries from the low half into the high half.
- R3: The control register sits at word 5. Bit 0 is run, bit 1 is comparator enable and bit 2 is auto-increment. It reads back what was written, with zeros above bit 2.
- R4: A match is full 64-bit equality of counter and comparator while run and comparator enable are both set. A match sets the status bit (word 7, bit 0) at the next clock edge, whatever the interrupt enable holds. Without comparator enable, no match occurs.
- R5: `irq_o` is high exactly when the status bit and the interrupt enable (word 6, bit 0) are both set. Writing 1 to word 7 bit 0 clears the status bit.
- R6: With auto-increment set, each match adds the step register (word 4) to the comparator (words 2 low and 3 high). Without auto-increment the comparator keeps its value.
- R7: The write-status register at word 8 has bit 0 for comparator low, bit 1 for comparator high, bit 2 for the step register and bit 16 for the control register. A bit sets one clock after the edge that accepts the write. Writing 1 to a bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: The counter write-status register at word 9 has bit 0 for counter low and bit 1 for counter high. It uses the same set timing and write-one-to-clear rule as R7.
- R9: Reads of unmapped words return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Word address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, accepted at the rising edge |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt: status AND enable |

## Verification
The bench pins down the exact edge at which a match raises the interrupt. A design that compared one cycle late, or that registered the interrupt an extra time, would show `irq_o` one sample late. In periodic mode the counter is stopped at a known cycle and the comparator is read back. A design that skipped a reload, or that let auto-increment act in one-shot mode, would read back the wrong comparator value. The carry from the low half into the high half is forced directly; a design that carried badly would read high word 0 after the low half wraps. The write-status bits are sampled both in the cycle just after the write and in the cycle after that. A design that set them too early, or never, would be caught by one of those two samples.

// File: rtl/gct_pkg.sv
package gct_pkg;
   // word offsets on the register bus
   localparam int unsigned A_CNT_LO  = 0;
   localparam int unsigned A_CNT_HI  = 1;
   localparam int unsigned A_CMP_LO  = 2;
   localparam int unsigned A_CMP_HI  = 3;
   localparam int unsigned A_STEP    = 4;
   localparam int unsigned A_CTRL    = 5;
   localparam int unsigned A_IEN     = 6;
   localparam int unsigned A_ISTAT   = 7;
   localparam int unsigned A_WST_CMP = 8;
   localparam int unsigned A_WST_CNT = 9;

   // bit positions inside the comparator write-status word
   localparam int unsigned WB_CMP_LO = 0;
   localparam int unsigned WB_CMP_HI = 1;
   localparam int unsigned WB_STEP   = 2;
   localparam int unsigned WB_CTRL   = 16;

   typedef struct packed {
      logic auto_inc;
      logic cmp_en;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/gct_counter.sv
module gct_counter #(
   parameter int unsigned HALF_W = 32,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt
);
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_d;

   assign cnt_inc = cnt + CNT_W'(1);

   // a write to either half wins over the increment in that cycle
   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         always_comb begin
            if ((h == 0) ? wr_lo : wr_hi)
               cnt_d[h*HALF_W +: HALF_W] = wdata;
            else if (wr_lo || wr_hi || !run)
               cnt_d[h*HALF_W +: HALF_W] = cnt[h*HALF_W +: HALF_W];
            else
               cnt_d[h*HALF_W +: HALF_W] = cnt_inc[h*HALF_W +: HALF_W];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end
endmodule

// File: rtl/gct_compare.sv
module gct_compare #(
   parameter int unsigned HALF_W = 32,
   localparam int unsigned CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              run,
   input  logic              cmp_en,
   input  logic              auto_inc,
   input  logic [HALF_W-1:0] step,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   input  logic              clr_stat,
   output logic [CNT_W-1:0]  cmp,
   output logic              match,
   output logic              status
);
   logic [CNT_W-1:0] cmp_next;
   logic [CNT_W-1:0] cmp_d;

   assign match    = run && cmp_en && (cnt == cmp);
   assign cmp_next = cmp + CNT_W'(step);

   // a bus write to a half wins over the periodic reload
   always_comb begin
      cmp_d = cmp;
      if (wr_lo || wr_hi) begin
         if (wr_lo) cmp_d[HALF_W-1:0]     = wdata;
         if (wr_hi) cmp_d[CNT_W-1:HALF_W] = wdata;
      end else if (match && auto_inc) begin
         cmp_d = cmp_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp    <= '0;
         status <= 1'b0;
      end else begin
         cmp <= cmp_d;
         if (match)         status <= 1'b1;
         else if (clr_stat) status <= 1'b0;
      end
   end
endmodule

// File: rtl/gct_wstat.sv
module gct_wstat #(
   parameter int unsigned NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] wr_evt,
   input  logic [NBITS-1:0] clr,
   output logic [NBITS-1:0] st
);
   logic [NBITS-1:0] pend;

   // a write is noted at its accepting edge and confirmed one edge later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         st   <= '0;
      end else begin
         pend <= wr_evt;
         st   <= (st & ~clr) | pend;
      end
   end
endmodule

// File: rtl/gct_timer.sv
module gct_timer #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   import gct_pkg::*;

   localparam int unsigned CNT_W = 2 * DATA_W;
   localparam int unsigned NWA   = 4;
   localparam int unsigned NWB   = 2;

   generate
      if (DATA_W <= WB_CTRL) begin : g_bad_width
         $error("DATA_W must exceed the control write-status bit position");
      end
      if ((1 << ADDR_W) <= A_WST_CNT) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic        wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
   logic        wr_step, wr_ctrl, wr_ien, wr_istat, wr_wsa, wr_wsb;
   ctrl_t       ctrl;
   logic        run, cmp_en, auto_inc;
   logic        ien;
   logic [DATA_W-1:0] step;
   logic [CNT_W-1:0]  cnt, cmp;
   logic        match, status;
   logic [NWA-1:0] wsa_st, wsa_clr;
   logic [NWB-1:0] wsb_st, wsb_clr;
   logic [DATA_W-1:0] wst_a, wst_b;

   always_comb begin
      wr_cnt_lo = bus_we && (bus_addr == ADDR_W'(A_CNT_LO));
      wr_cnt_hi = bus_we && (bus_addr == ADDR_W'(A_CNT_HI));
      wr_cmp_lo = bus_we && (bus_addr == ADDR_W'(A_CMP_LO));
      wr_cmp_hi = bus_we && (bus_addr == ADDR_W'(A_CMP_HI));
      wr_step   = bus_we && (bus_addr == ADDR_W'(A_STEP));
      wr_ctrl   = bus_we && (bus_addr == ADDR_W'(A_CTRL));
      wr_ien    = bus_we && (bus_addr == ADDR_W'(A_IEN));
      wr_istat  = bus_we && (bus_addr == ADDR_W'(A_ISTAT));
      wr_wsa    = bus_we && (bus_addr == ADDR_W'(A_WST_CMP));
      wr_wsb    = bus_we && (bus_addr == ADDR_W'(A_WST_CNT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         ien  <= 1'b0;
         step <= '0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[2:0]);
         if (wr_ien)  ien  <= bus_wdata[0];
         if (wr_step) step <= bus_wdata;
      end
   end

   assign run      = ctrl.run;
   assign cmp_en   = ctrl.cmp_en;
   assign auto_inc = ctrl.auto_inc;

   gct_counter #(.HALF_W(DATA_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .wr_lo (wr_cnt_lo),
      .wr_hi (wr_cnt_hi),
      .wdata (bus_wdata),
      .cnt   (cnt)
   );

   gct_compare #(.HALF_W(DATA_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .run      (run),
      .cmp_en   (cmp_en),
      .auto_inc (auto_inc),
      .step     (step),
      .wr_lo    (wr_cmp_lo),
      .wr_hi    (wr_cmp_hi),
      .wdata    (bus_wdata),
      .clr_stat (wr_istat && bus_wdata[0]),
      .cmp      (cmp),
      .match    (match),
      .status   (status)
   );

   assign wsa_clr = wr_wsa ? {bus_wdata[WB_CTRL], bus_wdata[WB_STEP],
                              bus_wdata[WB_CMP_HI], bus_wdata[WB_CMP_LO]} : '0;
   assign wsb_clr = wr_wsb ? bus_wdata[1:0] : '0;

   gct_wstat #(.NBITS(NWA)) u_wsa (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_evt ({wr_ctrl, wr_step, wr_cmp_hi, wr_cmp_lo}),
      .clr    (wsa_clr),
      .st     (wsa_st)
   );

   gct_wstat #(.NBITS(NWB)) u_wsb (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_evt ({wr_cnt_hi, wr_cnt_lo}),
      .clr    (wsb_clr),
      .st     (wsb_st)
   );

   always_comb begin
      wst_a            = '0;
      wst_a[WB_CMP_LO] = wsa_st[0];
      wst_a[WB_CMP_HI] = wsa_st[1];
      wst_a[WB_STEP]   = wsa_st[2];
      wst_a[WB_CTRL]   = wsa_st[3];
      wst_b            = DATA_W'(wsb_st);
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(A_CNT_LO):  bus_rdata = cnt[DATA_W-1:0];
         ADDR_W'(A_CNT_HI):  bus_rdata = cnt[CNT_W-1:DATA_W];
         ADDR_W'(A_CMP_LO):  bus_rdata = cmp[DATA_W-1:0];
         ADDR_W'(A_CMP_HI):  bus_rdata = cmp[CNT_W-1:DATA_W];
         ADDR_W'(A_STEP):    bus_rdata = step;
         ADDR_W'(A_CTRL):    bus_rdata = DATA_W'(ctrl);
         ADDR_W'(A_IEN):     bus_rdata = DATA_W'(ien);
         ADDR_W'(A_ISTAT):   bus_rdata = DATA_W'(status);
         ADDR_W'(A_WST_CMP): bus_rdata = wst_a;
         ADDR_W'(A_WST_CNT): bus_rdata = wst_b;
         default:            bus_rdata = '0;
      endcase
   end

   assign irq_o = status & ien;
endmodule

// File: rtl/gct_checker.sv
module gct_checker #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_o,
   input logic              ien,
   input logic              status,
   input logic              match,
   input logic              run,
   input logic              auto_inc,
   input logic              wr_cnt_lo,
   input logic              wr_cnt_hi,
   input logic              wr_cmp_lo,
   input logic              wr_cmp_hi,
   input logic [DATA_W-1:0] step,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic [DATA_W-1:0] wst_a
);
   // R5
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status && ien));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wr_cnt_lo && !wr_cnt_hi) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R4
   match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> status);

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && auto_inc && !wr_cmp_lo && !wr_cmp_hi)
      |=> (cmp == $past(cmp) + CNT_W'($past(step))));

   // R7
   wst_cmp_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp_lo |=> ##1 wst_a[0]);
endmodule

bind gct_timer gct_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .ien       (ien),
   .status    (status),
   .match     (match),
   .run       (run),
   .auto_inc  (auto_inc),
   .wr_cnt_lo (wr_cnt_lo),
   .wr_cnt_hi (wr_cnt_hi),
   .wr_cmp_lo (wr_cmp_lo),
   .wr_cmp_hi (wr_cmp_hi),
   .step      (step),
   .cnt       (cnt),
   .cmp       (cmp),
   .wst_a     (wst_a)
);

// File: tb/gct_timer_test.sv
module gct_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   gct_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   // entry: {read, addr, data}; a read compares data, a write drives it
   localparam int NV = 25;
   localparam logic [36:0] VEC [NV] = '{
      {1'b1, 4'd5, 32'h0},         // R1 control after reset
      {1'b1, 4'd0, 32'h0},         // R1 counter low after reset
      {1'b1, 4'd8, 32'h0},         // R1 write-status after reset
      {1'b0, 4'd0, 32'h10},
      {1'b0, 4'd1, 32'h5},
      {1'b1, 4'd0, 32'h10},        // R2 low half
      {1'b1, 4'd1, 32'h5},         // R2 high half
      {1'b1, 4'd9, 32'h3},         // R8 both counter bits set
      {1'b0, 4'd9, 32'h1},
      {1'b1, 4'd9, 32'h2},         // R8 clear of bit 0 only
      {1'b0, 4'd2, 32'h20},
      {1'b0, 4'd3, 32'h5},
      {1'b0, 4'd4, 32'h8},
      {1'b0, 4'd5, 32'hFFFF_FFFA},
      {1'b1, 4'd5, 32'h2},         // R3 only low three bits kept
      {1'b1, 4'd8, 32'h0001_0007}, // R7 all four bits
      {1'b0, 4'd8, 32'h0001_0007},
      {1'b1, 4'd8, 32'h0},         // R7 write-one clears
      {1'b1, 4'd3, 32'h5},         // R6 comparator high
      {1'b1, 4'd4, 32'h8},         // R6 step
      {1'b0, 4'd6, 32'h1},
      {1'b1, 4'd6, 32'h1},         // R5 enable reads back
      {1'b1, 4'd7, 32'h0},         // R4 no match yet
      {1'b0, 4'd12, 32'hDEAD},
      {1'b1, 4'd12, 32'h0}         // R9 unmapped word
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1 check(req, bus_rdata, exp);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 20000", cyc);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_addr = 4'd7;
      #1 check("R1 irq", {31'b0, irq_o}, 32'h0);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][36]) rd($sformatf("vector %0d", i), VEC[i][35:32], VEC[i][31:0]);
         else            wr(VEC[i][35:32], VEC[i][31:0]);
      end

      // periodic: match at 10, then every 5 counts
      wr(4'd0, 32'd0); wr(4'd1, 32'd0);
      wr(4'd2, 32'd10); wr(4'd3, 32'd0); wr(4'd4, 32'd5);
      wr(4'd5, 32'd7);
      for (int k = 1; k <= 30; k++) begin
         @(negedge clk);
         if (k == 10) check("R5 irq before match", {31'b0, irq_o}, 32'h0);
         if (k == 11) check("R5 irq one edge after match", {31'b0, irq_o}, 32'h1);
      end
      wr(4'd5, 32'd0);
      rd("R2 count when stopped", 4'd0, 32'd31);
      rd("R6 comparator after five reloads", 4'd2, 32'd35);
      wr(4'd7, 32'd1);
      rd("R5 status cleared", 4'd7, 32'd0);
      check("R5 irq cleared", {31'b0, irq_o}, 32'h0);

      // one-shot with interrupt disabled
      wr(4'd6, 32'd0);
      wr(4'd0, 32'd0); wr(4'd2, 32'd4);
      wr(4'd5, 32'd3);
      repeat (10) @(negedge clk);
      wr(4'd5, 32'd0);
      rd("R4 status set with interrupt off", 4'd7, 32'd1);
      check("R5 irq masked", {31'b0, irq_o}, 32'h0);
      rd("R6 one-shot comparator kept", 4'd2, 32'd4);

      // comparator disabled: no match
      wr(4'd7, 32'd1);
      wr(4'd0, 32'd0);
      wr(4'd5, 32'd1);
      repeat (10) @(negedge clk);
      wr(4'd5, 32'd0);
      rd("R4 no match while disabled", 4'd7, 32'd0);

      // carry from low into high half
      wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'd0);
      wr(4'd5, 32'd1);
      wr(4'd5, 32'd0);
      rd("R2 carry low", 4'd0, 32'd0);
      rd("R2 carry high", 4'd1, 32'd1);

      // write-status timing
      wr(4'd8, 32'h0001_0007);
      wr(4'd2, 32'h55);
      rd("R7 not yet set", 4'd8, 32'h0);
      rd("R7 set one clock later", 4'd8, 32'h1);

      summary();
   end
endmodule